// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block watches the access streams of the two ports of a shared dual-port memory and keeps one interrupt flag per port. The two topmost words of the address space serve as mailboxes: the all-ones address belongs to the right port, and the address just below it belongs to the left port. When one port deposits a word in the other port's mailbox, the owner's interrupt is raised. The owner acknowledges by reading its own mailbox, which drops the interrupt.

A busy indication from an external arbiter can be present on either port. While a port's busy input is high, that port can neither raise the other side's interrupt nor clear its own. The message storage and the arbiter are outside this block. The block only observes the access strobes and drives the two active-low flags.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first cycle after it is released, both lIntN and rIntN are 1 (inactive). An asserted reset clears a pending flag.
- R2: A left write (lValid=1, lWrite=1) to address all-ones drives rIntN to 0. A right write to address all-ones minus one drives lIntN to 0. The output changes on the clock edge that samples the access.
- R3: A right read (rValid=1, rWrite=0) of address all-ones returns rIntN to 1. A left read of address all-ones minus one returns lIntN to 1.
- R4: A port that reads the other port's mailbox leaves that other port's flag unchanged.
- R5: A write into the other port's mailbox while the writer's busy input is 1 leaves the flag unchanged.
- R6: A read of a port's own mailbox while that port's busy input is 1 leaves its flag unchanged.
- R7: When a set and a clear of the same flag arrive in the same cycle, the flag ends up asserted (0).
- R8: Accesses to any address other than the two mailboxes change neither flag.
- R9: When the valid input is 0, the port's write, address and busy inputs have no effect.
- R10: A write by a port into its own mailbox does not change that port's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lValid | input | 1 | Left port access in this cycle |
| lWrite | input | 1 | Left access is a write (1) or a read (0) |
| lAddr | input | ADDR_W | Left access address |
| lBusy | input | 1 | Left port lost arbitration (active high) |
| rValid | input | 1 | Right port access in this cycle |
| rWrite | input | 1 | Right access is a write (1) or a read (0) |
| rAddr | input | ADDR_W | Right access address |
| rBusy | input | 1 | Right port lost arbitration (active high) |
| lIntN | output | 1 | Left interrupt, active low |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
The access table sets and clears each flag from the correct port and direction. It also tries the cross-reads, the busy-blocked set and clear, the writes by an owner into its own mailbox, and the non-mailbox and invalid accesses. Each of these differs from the accepted case by one input, so a decoder that checks the wrong port, the wrong direction or the wrong address is caught. Simultaneous set and clear on each flag separates the set-first priority from the reverse. A reset applied with both flags pending shows that reset reaches both registers.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  // strobes from the decoder to the flag registers
  typedef struct packed {
    logic setLeft;
    logic clrLeft;
    logic setRight;
    logic clrRight;
  } flagStrobes_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_irq_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              lValid,
  input  logic              lWrite,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusy,
  input  logic              rValid,
  input  logic              rWrite,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusy,
  output flagStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] RIGHT_BOX = '1;
  localparam logic [ADDR_W-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic lGo, rGo;

  // an access counts only when valid and not blocked by arbitration
  assign lGo = lValid & ~lBusy;
  assign rGo = rValid & ~rBusy;

  always_comb begin
    strobes.setRight = lGo &  lWrite & (lAddr == RIGHT_BOX);
    strobes.clrRight = rGo & ~rWrite & (rAddr == RIGHT_BOX);
    strobes.setLeft  = rGo &  rWrite & (rAddr == LEFT_BOX);
    strobes.clrLeft  = lGo & ~lWrite & (lAddr == LEFT_BOX);
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  flagStrobes_t strobes,
  output logic         lIntN,
  output logic         rIntN
);
  logic leftPend, rightPend;

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leftPend  <= 1'b0;
      rightPend <= 1'b0;
    end else begin
      if (strobes.setLeft)       leftPend <= 1'b1;
      else if (strobes.clrLeft)  leftPend <= 1'b0;
      if (strobes.setRight)      rightPend <= 1'b1;
      else if (strobes.clrRight) rightPend <= 1'b0;
    end
  end

  assign lIntN = ~leftPend;
  assign rIntN = ~rightPend;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lValid,
  input  logic              lWrite,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusy,
  input  logic              rValid,
  input  logic              rWrite,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusy,
  output logic              lIntN,
  output logic              rIntN
);
  flagStrobes_t strobes;

  mbox_decode #(.ADDR_W(ADDR_W)) uDecode (
    .lValid(lValid), .lWrite(lWrite), .lAddr(lAddr), .lBusy(lBusy),
    .rValid(rValid), .rWrite(rWrite), .rAddr(rAddr), .rBusy(rBusy),
    .strobes(strobes)
  );

  mbox_flags uFlags (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lIntN(lIntN), .rIntN(rIntN)
  );
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lValid,
  input logic              lWrite,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lBusy,
  input logic              rValid,
  input logic              rWrite,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rBusy,
  input logic              lIntN,
  input logic              rIntN
);
  localparam logic [ADDR_W-1:0] RBOX = '1;
  localparam logic [ADDR_W-1:0] LBOX = RBOX - 1'b1;

  logic rSetReq, rClrReq, lSetReq, lClrReq;
  assign rSetReq = lValid && !lBusy && lWrite && lAddr == RBOX;
  assign rClrReq = rValid && !rBusy && !rWrite && rAddr == RBOX;
  assign lSetReq = rValid && !rBusy && rWrite && rAddr == LBOX;
  assign lClrReq = lValid && !lBusy && !lWrite && lAddr == LBOX;

  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rSetReq |=> !rIntN); // R2
  AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lSetReq |=> !lIntN); // R2
  AST_RIGHT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rClrReq && !rSetReq) |=> rIntN); // R3
  AST_LEFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (lClrReq && !lSetReq) |=> lIntN); // R3
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rSetReq && !rClrReq) |=> $stable(rIntN)); // R8
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lSetReq && !lClrReq) |=> $stable(lIntN)); // R8
endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst_n(rst_n),
  .lValid(lValid), .lWrite(lWrite), .lAddr(lAddr), .lBusy(lBusy),
  .rValid(rValid), .rWrite(rWrite), .rAddr(rAddr), .rBusy(rBusy),
  .lIntN(lIntN), .rIntN(rIntN)
);

// File: tb/tb_mbox_irq_ctrl.sv
module tb_mbox_irq_ctrl;
  localparam int AW = 14;
  localparam logic [AW-1:0] RB = '1;
  localparam logic [AW-1:0] LB = RB - 1'b1;
  localparam logic [AW-1:0] OT = 14'h0123;

  typedef struct packed {
    logic lV, lW, lB; logic [AW-1:0] lA;
    logic rV, rW, rB; logic [AW-1:0] rA;
    logic eL, eR; logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1,1,0,RB, 0,0,0,OT, 1,0, 4'd2},  // R2 left sets right
    '{1,0,0,RB, 0,0,0,OT, 1,0, 4'd4},  // R4 left peeks right box
    '{0,0,0,OT, 1,0,1,RB, 1,0, 4'd6},  // R6 busy blocks right clear
    '{0,0,0,OT, 1,0,0,RB, 1,1, 4'd3},  // R3 right clears
    '{1,1,1,RB, 0,0,0,OT, 1,1, 4'd5},  // R5 busy blocks left set
    '{0,0,0,OT, 1,1,0,LB, 0,1, 4'd2},  // R2 right sets left
    '{0,0,0,OT, 1,0,0,LB, 0,1, 4'd4},  // R4 right peeks left box
    '{1,0,1,LB, 0,0,0,OT, 0,1, 4'd6},  // R6 busy blocks left clear
    '{1,1,0,OT, 1,0,0,OT, 0,1, 4'd8},  // R8 other address
    '{1,0,0,LB, 0,0,0,OT, 1,1, 4'd3},  // R3 left clears
    '{0,0,0,OT, 1,1,1,LB, 1,1, 4'd5},  // R5 busy blocks right set
    '{0,1,0,RB, 0,1,0,LB, 1,1, 4'd9},  // R9 invalid accesses
    '{1,1,0,RB, 1,0,0,RB, 1,0, 4'd7},  // R7 right set beats clear
    '{1,0,0,LB, 1,1,0,LB, 0,0, 4'd7},  // R7 left set beats clear
    '{1,1,0,LB, 1,1,0,RB, 0,0, 4'd10}, // R10 own-box writes
    '{1,0,0,LB, 1,0,0,RB, 1,1, 4'd3}   // R3 both clear
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lValid = 0, lWrite = 0, lBusy = 0, rValid = 0, rWrite = 0, rBusy = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lIntN, rIntN;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_irq_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .lValid(lValid), .lWrite(lWrite), .lAddr(lAddr), .lBusy(lBusy),
    .rValid(rValid), .rWrite(rWrite), .rAddr(rAddr), .rBusy(rBusy),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  task automatic check(input int req, input logic eL, input logic eR);
    checks++;
    if (lIntN !== eL || rIntN !== eR) begin
      failures++;
      $display("FAIL R%0d: lIntN=%b rIntN=%b expected %b %b", req, lIntN, rIntN, eL, eR);
    end
  endtask

  task automatic idle();
    lValid = 0; lWrite = 0; lBusy = 0; lAddr = '0;
    rValid = 0; rWrite = 0; rBusy = 0; rAddr = '0;
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    check(1, 1'b1, 1'b1); // R1 during reset
    rst_n = 1;
    @(negedge clk);
    check(1, 1'b1, 1'b1); // R1 after release
    for (int i = 0; i < NV; i++) begin
      lValid = TBL[i].lV; lWrite = TBL[i].lW; lBusy = TBL[i].lB; lAddr = TBL[i].lA;
      rValid = TBL[i].rV; rWrite = TBL[i].rW; rBusy = TBL[i].rB; rAddr = TBL[i].rA;
      @(negedge clk);
      check(int'(TBL[i].req), TBL[i].eL, TBL[i].eR);
    end
    // R1: reset with both flags pending
    lValid = 1; lWrite = 1; lAddr = RB; rValid = 1; rWrite = 1; rAddr = LB;
    @(negedge clk);
    check(2, 1'b0, 1'b0); // R2 both set at once
    idle();
    @(negedge clk);
    check(8, 1'b0, 1'b0); // R8 idle holds
    rst_n = 0;
    @(negedge clk);
    check(1, 1'b1, 1'b1); // R1 reset clears pending
    rst_n = 1;
    @(negedge clk);
    check(1, 1'b1, 1'b1); // R1
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule